// File: doc/BRIEF.md
# Two-Dimensional Strided Burst Address Generator

This block accepts one transfer request at a time and turns it into a stream of burst addresses for a memory-side bus. A request describes a rectangle: a number of rows, each a fixed number of bytes long. Each row begins a programmable stride past the beginning of the row before it. Both lengths arrive encoded as the count minus one. Rows are cut into bursts of bounded length that never straddle a 4 KiB page. The generator ends each request with a one-cycle completion pulse that carries the request's tag. It also shows the address currently being issued, so that status can be read back.

A request with the repeat flag set starts again from its first address each time it completes, and keeps doing so with no further request. It ends only when the stop input is raised. The stop input ends address issue once the burst now on offer has been taken. The caller is expected to give a start address, a row length and a stride that are all whole multiples of the beat size. Bus protocol details and data movement are handled elsewhere.

Top module: `stride2d_agen`

## Requirements
- R1: While reset is held, req_ready is 1, burst_valid and eot_valid are 0, and cur_addr is 0.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. From the next cycle burst_valid is 1, and req_ready stays 0 until the generator is idle again.
- R3: A request covers req_ylen_m1+1 rows of req_xlen_m1+1 bytes each, so the bytes summed over all its bursts equal (req_xlen_m1+1)*(req_ylen_m1+1).
- R4: Row n (counted from 0) starts at req_addr + n*req_stride, and the bursts of a row follow each other at increasing, contiguous addresses.
- R5: When req_ylen_m1 is 0, only one row is issued and req_stride has no effect on any burst.
- R6: burst_len holds the beat count minus one. A beat is 2^BEAT_LOG2 bytes (4 by default), and no burst has more than MAX_BEATS beats (16 by default).
- R7: No burst crosses a 2^BOUND_LOG2-byte boundary (4 KiB by default). A burst is cut short at the boundary and the next burst starts exactly on it.
- R8: While burst_valid is 1 and burst_ready is 0, burst_valid stays 1 and burst_addr and burst_len do not change on the next cycle.
- R9: eot_valid is 1 for exactly the one cycle after the handshake of a request's final burst, and eot_id then equals the req_id captured when the request was taken.
- R10: With req_cyclic set, the burst after each final burst starts again at req_addr with the same geometry. An eot pulse is given for every pass, and this continues with no new request.
- R11: If abort is 1 in a cycle where a burst is handshaken, or in any earlier cycle of the same request, no further burst follows and the generator goes idle. eot is given only if that burst was the final burst of a pass. While idle, abort keeps req_ready at 0.
- R12: While busy, cur_addr equals burst_addr. When idle, it holds the address of the last burst that was handshaken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Generator idle and able to take a request |
| req_addr | input | ADDR_W | First byte address of the request |
| req_xlen_m1 | input | XLEN_W | Bytes per row minus one |
| req_ylen_m1 | input | YLEN_W | Row count minus one |
| req_stride | input | ADDR_W | Byte distance between consecutive row starts |
| req_cyclic | input | 1 | Repeat the request until stopped |
| req_id | input | ID_W | Tag returned with the completion pulse |
| abort | input | 1 | Stop issuing after the burst on offer |
| burst_valid | output | 1 | Burst address and length offered |
| burst_ready | input | 1 | Downstream takes the burst |
| burst_addr | output | ADDR_W | Burst start address |
| burst_len | output | BLEN_W | Burst beats minus one |
| eot_valid | output | 1 | One-cycle pulse when a request pass completes |
| eot_id | output | ID_W | Tag of the completed request |
| cur_addr | output | ADDR_W | Address currently issued, for readback |

## Verification
The hardest coincidence comes from two events that share one clock edge. One is the handshake of a cyclic request's final burst, which would reload the request. The other is the stop input. The bench runs a one-burst cyclic request with ready held high, so every handshake is a final one, and raises abort for a single cycle. The cycle-accurate model expects the completion pulse of that pass, exactly one more burst, and then idle. A second case meets a 4 KiB page edge in the middle of a row, with ready toggling. The model predicts the split and expects the held burst to stay unchanged while it waits.

// File: rtl/s2d_pkg.sv
// Package: shared types for the two-dimensional strided address generator.
// Assumes: nothing beyond IEEE 1800-2017.
package s2d_pkg;

    // Sequencer state: idle waiting for a request, or issuing bursts.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } s2d_state_e;

endpackage

// File: rtl/s2d_burst_calc.sv
// Module: s2d_burst_calc
// Sizes the next burst: the smallest of the bytes left in the current row,
// the largest burst allowed, and the room left before the next page boundary.
// Assumes: the address and row_left are multiples of the beat size, and
// CNT_W is wider than BOUND_LOG2.
module s2d_burst_calc #(
    parameter int CNT_W      = 17,
    parameter int BEAT_LOG2  = 2,
    parameter int MAX_BEATS  = 16,
    parameter int BOUND_LOG2 = 12,
    parameter int BLEN_W     = 4
) (
    input  logic [BOUND_LOG2-1:0] addr_lo,
    input  logic [CNT_W-1:0]      row_left,
    output logic [CNT_W-1:0]      step_bytes,
    output logic [BLEN_W-1:0]     len_m1
);

    localparam int BOUND_BYTES = 1 << BOUND_LOG2;
    localparam int MAX_BYTES   = MAX_BEATS << BEAT_LOG2;
    localparam logic [CNT_W-1:0] BOUND_C = CNT_W'(BOUND_BYTES);
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_BYTES);

    logic [CNT_W-1:0] room;
    logic [CNT_W-1:0] capped;
    logic [CNT_W-1:0] beats;

    // Pick the limiting distance and encode it as beats minus one.
    always_comb begin
        room       = BOUND_C - CNT_W'(addr_lo);
        capped     = (row_left < MAX_C) ? row_left : MAX_C;
        step_bytes = (room < capped) ? room : capped;
        beats      = step_bytes >> BEAT_LOG2;
        len_m1     = BLEN_W'(beats - CNT_W'(1));
    end

endmodule

// File: rtl/s2d_walker.sv
// Module: s2d_walker
// Holds the captured request and walks the rectangle: the current address,
// the start of the current row, the bytes left in the row and the rows left.
// Assumes: load, relaunch and advance are never high together (the
// sequencer guarantees this), and step_bytes is never zero while advancing.
module s2d_walker #(
    parameter int ADDR_W = 32,
    parameter int XLEN_W = 16,
    parameter int YLEN_W = 16,
    parameter int ID_W   = 4,
    parameter int CNT_W  = XLEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              relaunch,
    input  logic              advance,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [XLEN_W-1:0] in_xlen_m1,
    input  logic [YLEN_W-1:0] in_ylen_m1,
    input  logic [ADDR_W-1:0] in_stride,
    input  logic              in_cyclic,
    input  logic [ID_W-1:0]   in_id,
    input  logic [CNT_W-1:0]  step_bytes,
    output logic [ADDR_W-1:0] cur,
    output logic [CNT_W-1:0]  row_left,
    output logic              row_end,
    output logic              last_row,
    output logic              cfg_cyclic,
    output logic [ID_W-1:0]   cfg_id
);

    logic [ADDR_W-1:0] cfg_addr;
    logic [XLEN_W-1:0] cfg_xlen_m1;
    logic [YLEN_W-1:0] cfg_ylen_m1;
    logic [ADDR_W-1:0] cfg_stride;
    logic [ADDR_W-1:0] row_base;
    logic [YLEN_W-1:0] rows_left;
    logic [ADDR_W-1:0] next_row;
    logic [CNT_W-1:0]  row_bytes;

    // Decode where the walk stands relative to the row and the rectangle.
    always_comb begin
        row_end   = (step_bytes == row_left);
        last_row  = (rows_left == '0);
        next_row  = row_base + cfg_stride;
        row_bytes = CNT_W'(cfg_xlen_m1) + CNT_W'(1);
    end

    // Capture the request fields when a new request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_addr    <= '0;
            cfg_xlen_m1 <= '0;
            cfg_ylen_m1 <= '0;
            cfg_stride  <= '0;
            cfg_cyclic  <= 1'b0;
            cfg_id      <= '0;
        end else if (load) begin
            cfg_addr    <= in_addr;
            cfg_xlen_m1 <= in_xlen_m1;
            cfg_ylen_m1 <= in_ylen_m1;
            cfg_stride  <= in_stride;
            cfg_cyclic  <= in_cyclic;
            cfg_id      <= in_id;
        end
    end

    // Move the walk position: start, restart, next burst or next row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur       <= '0;
            row_base  <= '0;
            row_left  <= '0;
            rows_left <= '0;
        end else if (load) begin
            cur       <= in_addr;
            row_base  <= in_addr;
            row_left  <= CNT_W'(in_xlen_m1) + CNT_W'(1);
            rows_left <= in_ylen_m1;
        end else if (relaunch) begin
            cur       <= cfg_addr;
            row_base  <= cfg_addr;
            row_left  <= row_bytes;
            rows_left <= cfg_ylen_m1;
        end else if (advance) begin
            if (row_end) begin
                cur       <= next_row;
                row_base  <= next_row;
                row_left  <= row_bytes;
                rows_left <= rows_left - YLEN_W'(1);
            end else begin
                cur      <= cur + ADDR_W'(step_bytes);
                row_left <= row_left - step_bytes;
            end
        end
    end

    // R3
    adv_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !(row_end && last_row));

    // R4
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && row_end) |=> (cur == row_base));

endmodule

// File: rtl/s2d_seq.sv
// Module: s2d_seq
// Control sequencer: takes requests, offers bursts, decides between the
// next burst, a cyclic restart, a stop and a return to idle, and raises the
// completion pulse.
// Assumes: row_end and last_row describe the burst now on offer.
module s2d_seq
    import s2d_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            abort,
    input  logic            burst_ready,
    input  logic            row_end,
    input  logic            last_row,
    input  logic            cfg_cyclic,
    input  logic [ID_W-1:0] cfg_id,
    output logic            req_ready,
    output logic            burst_valid,
    output logic            load,
    output logic            relaunch,
    output logic            advance,
    output logic            eot_valid,
    output logic [ID_W-1:0] eot_id
);

    s2d_state_e state;
    s2d_state_e state_n;
    logic       stop_q;
    logic       running;
    logic       hs;
    logic       last_burst;
    logic       stop_now;

    // Derive the handshake and the walk commands for this cycle.
    always_comb begin
        running     = (state == ST_RUN);
        req_ready   = !running && !abort;
        burst_valid = running;
        hs          = running && burst_ready;
        last_burst  = row_end && last_row;
        stop_now    = abort || stop_q;
        load        = req_valid && req_ready;
        relaunch    = hs && last_burst && cfg_cyclic && !stop_now;
        advance     = hs && !last_burst && !stop_now;
    end

    // Choose the next state.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (load) state_n = ST_RUN;
            ST_RUN:  if (hs && !relaunch && !advance) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Update the state and remember a stop raised while a burst waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            stop_q <= 1'b0;
        end else begin
            state  <= state_n;
            stop_q <= running && (state_n == ST_RUN) && stop_now;
        end
    end

    // Raise the completion pulse after the final burst of a pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eot_valid <= 1'b0;
            eot_id    <= '0;
        end else begin
            eot_valid <= hs && last_burst;
            if (hs && last_burst) eot_id <= cfg_id;
        end
    end

    // R2
    accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (burst_valid && !req_ready));

    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && !burst_ready) |=> burst_valid);

    // R9
    eot_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot_valid |-> $past(burst_valid && burst_ready));

    // R11
    abort_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && burst_ready && abort) |=> !burst_valid);

endmodule

// File: rtl/stride2d_agen.sv
// Module: stride2d_agen (top)
// Two-dimensional strided burst address generator. It walks rows of a
// rectangle, cuts each row into page-safe bursts of bounded length, can
// repeat the request forever, and can be stopped after the burst on offer.
// Assumes: the start address, the row length and the stride are multiples
// of the beat size 2^BEAT_LOG2, and BOUND_LOG2 < XLEN_W.
module stride2d_agen #(
    parameter int ADDR_W     = 32,
    parameter int XLEN_W     = 16,
    parameter int YLEN_W     = 16,
    parameter int ID_W       = 4,
    parameter int BEAT_LOG2  = 2,
    parameter int MAX_BEATS  = 16,
    parameter int BOUND_LOG2 = 12,
    localparam int BLEN_W    = $clog2(MAX_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [XLEN_W-1:0] req_xlen_m1,
    input  logic [YLEN_W-1:0] req_ylen_m1,
    input  logic [ADDR_W-1:0] req_stride,
    input  logic              req_cyclic,
    input  logic [ID_W-1:0]   req_id,
    input  logic              abort,
    output logic              burst_valid,
    input  logic              burst_ready,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [BLEN_W-1:0] burst_len,
    output logic              eot_valid,
    output logic [ID_W-1:0]   eot_id,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int CNT_W       = XLEN_W + 1;
    localparam int BOUND_BYTES = 1 << BOUND_LOG2;

    logic [ADDR_W-1:0] cur;
    logic [CNT_W-1:0]  row_left;
    logic [CNT_W-1:0]  step_bytes;
    logic              row_end;
    logic              last_row;
    logic              cfg_cyclic;
    logic [ID_W-1:0]   cfg_id;
    logic              load;
    logic              relaunch;
    logic              advance;

    s2d_burst_calc #(
        .CNT_W      (CNT_W),
        .BEAT_LOG2  (BEAT_LOG2),
        .MAX_BEATS  (MAX_BEATS),
        .BOUND_LOG2 (BOUND_LOG2),
        .BLEN_W     (BLEN_W)
    ) u_calc (
        .addr_lo    (cur[BOUND_LOG2-1:0]),
        .row_left   (row_left),
        .step_bytes (step_bytes),
        .len_m1     (burst_len)
    );

    s2d_walker #(
        .ADDR_W (ADDR_W),
        .XLEN_W (XLEN_W),
        .YLEN_W (YLEN_W),
        .ID_W   (ID_W),
        .CNT_W  (CNT_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .relaunch   (relaunch),
        .advance    (advance),
        .in_addr    (req_addr),
        .in_xlen_m1 (req_xlen_m1),
        .in_ylen_m1 (req_ylen_m1),
        .in_stride  (req_stride),
        .in_cyclic  (req_cyclic),
        .in_id      (req_id),
        .step_bytes (step_bytes),
        .cur        (cur),
        .row_left   (row_left),
        .row_end    (row_end),
        .last_row   (last_row),
        .cfg_cyclic (cfg_cyclic),
        .cfg_id     (cfg_id)
    );

    s2d_seq #(
        .ID_W (ID_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .abort       (abort),
        .burst_ready (burst_ready),
        .row_end     (row_end),
        .last_row    (last_row),
        .cfg_cyclic  (cfg_cyclic),
        .cfg_id      (cfg_id),
        .req_ready   (req_ready),
        .burst_valid (burst_valid),
        .load        (load),
        .relaunch    (relaunch),
        .advance     (advance),
        .eot_valid   (eot_valid),
        .eot_id      (eot_id)
    );

    // Drive the burst address and the readback copy from the walk position.
    always_comb begin
        burst_addr = cur;
        cur_addr   = cur;
    end

    // R8
    burst_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && !burst_ready) |=> ($stable(burst_addr) && $stable(burst_len)));

    // R7
    no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> ((32'(burst_addr[BOUND_LOG2-1:0]) +
                          ((32'(burst_len) + 32'd1) << BEAT_LOG2)) <= 32'(BOUND_BYTES)));

endmodule

// File: tb/stride2d_agen_tb.sv
// Bench for stride2d_agen: a behavioural model expands each request into a
// queue of expected bursts and is compared with the design on every clock.
module stride2d_agen_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  len;
    } bst_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_xlen_m1 = '0;
    logic [15:0] req_ylen_m1 = '0;
    logic [31:0] req_stride = '0;
    logic        req_cyclic = 1'b0;
    logic [3:0]  req_id = '0;
    logic        abort = 1'b0;
    logic        burst_valid;
    logic        burst_ready = 1'b0;
    logic [31:0] burst_addr;
    logic [3:0]  burst_len;
    logic        eot_valid;
    logic [3:0]  eot_id;
    logic [31:0] cur_addr;

    stride2d_agen u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_xlen_m1 (req_xlen_m1),
        .req_ylen_m1 (req_ylen_m1), .req_stride (req_stride),
        .req_cyclic (req_cyclic), .req_id (req_id), .abort (abort),
        .burst_valid (burst_valid), .burst_ready (burst_ready),
        .burst_addr (burst_addr), .burst_len (burst_len),
        .eot_valid (eot_valid), .eot_id (eot_id), .cur_addr (cur_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int bytes_seen = 0, bursts_seen = 0, eot_seen = 0;
    int rdy_mode = 0;
    bit acc_seen = 0;

    bst_t        exp_q[$];
    bit          m_busy = 0, m_stop = 0, m_cyc = 0, m_eot = 0;
    logic [3:0]  m_eot_id = '0;
    logic [31:0] m_cur = '0;
    logic [31:0] c_addr = '0, c_stride = '0;
    int          c_xm1 = 0, c_ym1 = 0;
    logic [3:0]  c_id = '0;
    bit          p_hold = 0;
    logic [31:0] p_addr = '0;
    logic [3:0]  p_len = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected bursts for one pass: rows at stride, cut at 64 bytes and 4 KiB.
    task automatic build_pass();
        for (int r = 0; r <= c_ym1; r++) begin
            logic [31:0] a;
            int left, room, b;
            bst_t e;
            a = c_addr + 32'(r) * c_stride;
            left = c_xm1 + 1;
            while (left > 0) begin
                room = 4096 - int'(a[11:0]);
                b = left;
                if (b > 64) b = 64;
                if (b > room) b = room;
                e.addr = a;
                e.len = 4'(b / 4 - 1);
                exp_q.push_back(e);
                a = a + 32'(b);
                left = left - b;
            end
        end
    endtask

    // Reference model and per-cycle comparison, sampled before each rising edge.
    initial begin
        forever begin
            bst_t hd;
            bit stop_now;
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (!rst_n) begin
                exp_q.delete();
                m_busy = 0; m_stop = 0; m_eot = 0; m_cur = '0; p_hold = 0;
                continue;
            end
            chk(req_ready == (!m_busy && !abort), "R2 req_ready", req_ready, !m_busy && !abort);
            chk(burst_valid == m_busy, "R2 burst_valid", burst_valid, m_busy);
            chk(eot_valid == m_eot, "R9 eot_valid", eot_valid, m_eot);
            if (m_eot) chk(eot_id == m_eot_id, "R9 eot_id", eot_id, m_eot_id);
            if (eot_valid) eot_seen++;
            if (p_hold) chk(burst_addr == p_addr && burst_len == p_len, "R8 held burst",
                            {burst_addr, burst_len}, {p_addr, p_len});
            if (m_busy && exp_q.size() > 0) begin
                chk(burst_addr == exp_q[0].addr, "R4 burst_addr", burst_addr, exp_q[0].addr);
                chk(burst_len == exp_q[0].len, "R6 burst_len", burst_len, exp_q[0].len);
                chk(cur_addr == burst_addr, "R12 cur_addr busy", cur_addr, burst_addr);
            end else if (!m_busy) begin
                chk(cur_addr == m_cur, "R12 cur_addr idle", cur_addr, m_cur);
            end
            if (burst_valid)
                chk(int'(burst_addr[11:0]) + (int'(burst_len) + 1) * 4 <= 4096, "R7 page edge",
                    int'(burst_addr[11:0]) + (int'(burst_len) + 1) * 4, 4096);
            p_hold = burst_valid && !burst_ready;
            p_addr = burst_addr;
            p_len = burst_len;
            m_eot = 0;
            stop_now = abort || m_stop;
            if (m_busy && burst_ready) begin
                hd = exp_q.pop_front();
                m_cur = hd.addr;
                bursts_seen++;
                bytes_seen += (int'(burst_len) + 1) * 4;
                if (exp_q.size() == 0) begin
                    m_eot = 1;
                    m_eot_id = c_id;
                    if (m_cyc && !stop_now) build_pass();
                    else begin m_busy = 0; m_stop = 0; end
                end else if (stop_now) begin
                    m_busy = 0; m_stop = 0; exp_q.delete();
                end
            end else if (m_busy && abort) begin
                m_stop = 1;
            end else if (!m_busy && req_valid && !abort) begin
                c_addr = req_addr; c_xm1 = int'(req_xlen_m1); c_ym1 = int'(req_ylen_m1);
                c_stride = req_stride; c_id = req_id; m_cyc = req_cyclic;
                build_pass();
                m_busy = 1;
                acc_seen = 1;
            end
        end
    end

    // Downstream ready pattern: always, toggling, pseudo-random, or held low.
    initial begin
        logic [7:0] lfsr = 8'hA5;
        bit tog = 0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tog = !tog;
            case (rdy_mode)
                0: burst_ready <= 1'b1;
                1: burst_ready <= tog;
                2: burst_ready <= lfsr[0];
                default: burst_ready <= 1'b0;
            endcase
        end
    end

    task automatic clear_counts();
        bytes_seen = 0; bursts_seen = 0; eot_seen = 0;
    endtask

    task automatic send_req(input logic [31:0] a, input int xm1, input int ym1,
                            input logic [31:0] st, input bit cyc, input logic [3:0] id);
        @(negedge clk);
        req_addr = a; req_xlen_m1 = 16'(xm1); req_ylen_m1 = 16'(ym1);
        req_stride = st; req_cyclic = cyc; req_id = id;
        req_valid = 1'b1;
        acc_seen = 0;
        do @(posedge clk); while (!acc_seen);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && m_busy; i++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int b0, e0;
        repeat (3) @(posedge clk);
        #1;
        chk(req_ready == 1'b1, "R1 reset req_ready", req_ready, 1);
        chk(burst_valid == 1'b0, "R1 reset burst_valid", burst_valid, 0);
        chk(eot_valid == 1'b0, "R1 reset eot_valid", eot_valid, 0);
        chk(cur_addr == 32'h0, "R1 reset cur_addr", cur_addr, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R4: three rows of 100 bytes at stride 256.
        rdy_mode = 0; clear_counts();
        send_req(32'h1000, 99, 2, 32'h100, 1'b0, 4'd3);
        wait_idle();
        chk(bytes_seen == 300, "R3 total bytes", bytes_seen, 300);
        chk(eot_seen == 1, "R9 single eot", eot_seen, 1);

        // R5 R7: one row crossing a page edge, odd stride ignored.
        rdy_mode = 1; clear_counts();
        send_req(32'h1FF0, 127, 0, 32'h1234_5678, 1'b0, 4'd5);
        wait_idle();
        chk(bytes_seen == 128, "R5 one row only", bytes_seen, 128);
        chk(bursts_seen == 3, "R7 split count", bursts_seen, 3);
        chk(cur_addr == 32'h2040, "R12 idle cur_addr", cur_addr, 32'h2040);

        // R6: two 4 KiB rows, every burst at the beat cap.
        rdy_mode = 2; clear_counts();
        send_req(32'h5000, 4095, 1, 32'h2000, 1'b0, 4'd7);
        wait_idle();
        chk(bursts_seen == 128, "R6 burst count", bursts_seen, 128);
        chk(bytes_seen == 8192, "R3 large total", bytes_seen, 8192);

        // R10: cyclic request repeats until stopped.
        rdy_mode = 2; clear_counts();
        send_req(32'h300, 31, 1, 32'h100, 1'b1, 4'd9);
        for (int i = 0; i < 2000 && eot_seen < 3; i++) @(posedge clk);
        chk(eot_seen >= 3, "R10 passes repeat", eot_seen, 3);
        chk(m_busy == 1 && burst_valid == 1'b1, "R10 still running", burst_valid, 1);
        b0 = bursts_seen;
        pulse_abort();
        wait_idle();
        chk(bursts_seen - b0 <= 1, "R11 cyclic stop", bursts_seen - b0, 1);
        chk(burst_valid == 1'b0, "R11 idle after stop", burst_valid, 0);

        // R11: stop while the first burst waits; one burst, no eot.
        rdy_mode = 3; clear_counts();
        send_req(32'h8000, 255, 3, 32'h400, 1'b0, 4'd2);
        repeat (4) @(posedge clk);
        pulse_abort();
        rdy_mode = 0;
        wait_idle();
        chk(bursts_seen == 1, "R11 one burst after stop", bursts_seen, 1);
        chk(eot_seen == 0, "R11 no eot mid request", eot_seen, 0);
        chk(cur_addr == 32'h8000, "R12 cur after stop", cur_addr, 32'h8000);

        // R10 R11: stop coincides with the final burst of a cyclic pass.
        rdy_mode = 0; clear_counts();
        send_req(32'h600, 15, 0, 32'h0, 1'b1, 4'd12);
        repeat (5) @(posedge clk);
        @(negedge clk);
        b0 = bursts_seen; e0 = eot_seen;
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        wait_idle();
        chk(bursts_seen == b0 + 1, "R11 coincident stop bursts", bursts_seen, b0 + 1);
        chk(eot_seen == e0 + 2, "R10 coincident final eot", eot_seen, e0 + 2);

        // R11: abort while idle blocks a request.
        clear_counts();
        @(negedge clk);
        req_addr = 32'h9000; req_xlen_m1 = 16'd15; req_ylen_m1 = '0;
        req_cyclic = 1'b0; req_valid = 1'b1; abort = 1'b1;
        repeat (3) @(negedge clk);
        chk(burst_valid == 1'b0, "R11 idle abort blocks", burst_valid, 0);
        chk(req_ready == 1'b0, "R11 idle abort ready", req_ready, 0);
        req_valid = 1'b0; abort = 1'b0;
        repeat (3) @(posedge clk);
        chk(bursts_seen == 0, "R11 nothing issued", bursts_seen, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule